// File: doc/BRIEF.md
# Set/Clear GPIO Data Bank

This block holds the output data, per-line configuration and input view for two banks of general-purpose lines. Each bank has `LINES` lines (64 by default), so the block serves `2*LINES` pads. Software never writes the output data directly. It writes a mask to a set register or to a clear register, and only the lines whose mask bits are 1 change. Each line also has its own configuration word:

- an output enable,
- an inversion bit that applies to both directions,
- an open-drain mode,
- a 10-bit function select. A nonzero function select hands the pad to another function, and the line is then never driven as a GPIO.

Access is through a simple one-access-per-cycle register port. Writes take effect at the clock edge that accepts them. A small two-state machine returns read data. In `ST_IDLE` no response is pending. A read request moves it to `ST_RDATA`, where `bus_rvalid` is high for one cycle. A further read request keeps it in `ST_RDATA`, and any other cycle returns it to `ST_IDLE`. Pad outputs are combinational from the stored latch and configuration.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset, every output latch bit and every configuration word is zero, `pad_oe` and `pad_out` are all zero and `bus_rvalid` is low.
- R2: A write to bank offset 0x8 sets each latch bit of that bank whose write-data bit is 1 and leaves the bank's other bits unchanged.
- R3: A write to bank offset 0x10 clears each latch bit of that bank whose write-data bit is 1 and leaves the bank's other bits unchanged.
- R4: A read of offset 0x8 returns the bank's output latch in bits LINES-1:0. A read of offset 0x10 returns zero.
- R5: A read of offset 0x0 returns, for each line of the bank, `pad_in` XOR that line's inversion bit.
- R6: The configuration word of bank line i is at bank offset 0x400 + 8*i. Bit 0 is output enable, bit 1 is inversion, bit 12 is open-drain and bits 25:16 are the function select. A read returns those fields, and all other bits read as zero.
- R7: When a line has output enable set, a zero function select and open-drain clear, `pad_oe` is 1 and `pad_out` equals latch XOR inversion.
- R8: When a line has output enable set, a zero function select and open-drain set, `pad_out` is 0 and `pad_oe` is the inverse of latch XOR inversion. A logic 0 pulls the pad low, and a logic 1 releases it.
- R9: A line with a nonzero function select, or with output enable clear, has `pad_oe` 0 and `pad_out` 0.
- R10: The second bank is the same register map placed at address 0x1400. It serves lines LINES to 2*LINES-1 and is independent of the first bank.
- R11: A read of bank offset 0x90 returns the total line count in bits 7:0, the `BASE_VEC` parameter in bits 15:8, and zero in all other bits.
- R12: `bus_rvalid` is high in exactly the cycle after a read request, with `bus_rdata` valid in that cycle. A write produces no response.
- R13: A read of an unmapped or non-8-byte-aligned address returns zero. A write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read response strobe |
| pad_in | input | 2*LINES | Sampled pad levels |
| pad_out | output | 2*LINES | Pad output level |
| pad_oe | output | 2*LINES | Pad output enable |

## Verification
The assertions assume that `bus_req`, `bus_we` and `bus_addr` are known in every cycle after reset, and that the port carries at most one access per cycle. Under that assumption a set and a clear to the same bit can never arrive together. The stimulus follows a fixed-seed random stream and always drives a single complete access per transaction on the falling edge. The random stream keeps most function selects at zero so that the push-pull and open-drain drive paths are exercised often. It also randomises the unused configuration bits, to check that they are dropped.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
    localparam int OFS_RX     = 'h0;
    localparam int OFS_SET    = 'h8;
    localparam int OFS_CLR    = 'h10;
    localparam int OFS_CONST  = 'h90;
    localparam int OFS_CFG    = 'h400;
    localparam int BANK_OFS   = 'h1400;
    localparam int BIT_OE     = 0;
    localparam int BIT_INV    = 1;
    localparam int BIT_OD     = 12;
    localparam int FSEL_LO    = 16;
    localparam int FSEL_W     = 10;

    typedef enum logic [2:0] {
        REG_NONE, REG_RX, REG_SET, REG_CLR, REG_CONST, REG_CFG
    } reg_sel_e;

    typedef struct packed {
        logic [FSEL_W-1:0] fsel;
        logic              od;
        logic              inv;
        logic              oe;
    } line_cfg_t;

    typedef enum logic {ST_IDLE, ST_RDATA} rsp_state_e;
endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
    import gpio_sc_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int LINES  = 64,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              bank,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(OFS_CFG + 8 * LINES);

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] cfg_rel;

    always_comb begin
        bank    = (addr >= ADDR_W'(BANK_OFS));
        off     = bank ? (addr - ADDR_W'(BANK_OFS)) : addr;
        cfg_rel = off - ADDR_W'(OFS_CFG);
        idx     = cfg_rel[IDX_W+2:3];
        sel     = REG_NONE;
        if (off[2:0] == 3'b000) begin
            if (off == ADDR_W'(OFS_RX))          sel = REG_RX;
            else if (off == ADDR_W'(OFS_SET))    sel = REG_SET;
            else if (off == ADDR_W'(OFS_CLR))    sel = REG_CLR;
            else if (off == ADDR_W'(OFS_CONST))  sel = REG_CONST;
            else if (off >= ADDR_W'(OFS_CFG) && off < CFG_END) sel = REG_CFG;
        end
    end
endmodule

// File: rtl/gpio_sc_pad.sv
module gpio_sc_pad
    import gpio_sc_pkg::*;
#(
    parameter int N = 128
) (
    input  line_cfg_t        cfg [N],
    input  logic [N-1:0]     latch,
    input  logic [N-1:0]     pad_in,
    output logic [N-1:0]     pad_out,
    output logic [N-1:0]     pad_oe,
    output logic [N-1:0]     rx
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic is_gpio;
        logic lvl;
        logic en;
        assign is_gpio    = (cfg[i].fsel == '0);
        assign lvl        = latch[i] ^ cfg[i].inv;
        assign en         = cfg[i].oe & is_gpio;
        assign pad_oe[i]  = en & (cfg[i].od ? ~lvl : 1'b1);
        assign pad_out[i] = en & ~cfg[i].od & lvl;
        assign rx[i]      = pad_in[i] ^ cfg[i].inv;
    end
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
    import gpio_sc_pkg::*;
#(
    parameter int          LINES    = 64,
    parameter int          ADDR_W   = 13,
    parameter int          DATA_W   = 64,
    parameter logic [7:0]  BASE_VEC = 8'd48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_rvalid,
    input  logic [2*LINES-1:0]   pad_in,
    output logic [2*LINES-1:0]   pad_out,
    output logic [2*LINES-1:0]   pad_oe
);
    localparam int NL    = 2 * LINES;
    localparam int IDX_W = $clog2(LINES);

    reg_sel_e           dec_sel;
    logic               dec_bank;
    logic [IDX_W-1:0]   dec_idx;
    logic [NL-1:0]      out_q;
    line_cfg_t          cfg_q [NL];
    logic [NL-1:0]      rx_v;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;
    rsp_state_e         state_q, state_d;
    logic               wr_acc, rd_acc;
    int                 line_sel;
    line_cfg_t          cfg_rd;

    gpio_sc_decode #(.ADDR_W(ADDR_W), .LINES(LINES), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .sel  (dec_sel),
        .bank (dec_bank),
        .idx  (dec_idx)
    );

    gpio_sc_pad #(.N(NL)) u_pad (
        .cfg     (cfg_q),
        .latch   (out_q),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .rx      (rx_v)
    );

    assign wr_acc   = bus_req & bus_we;
    assign rd_acc   = bus_req & ~bus_we;
    assign line_sel = int'(dec_bank) * LINES + int'(dec_idx);
    assign cfg_rd   = cfg_q[line_sel];

    // Storage: set/clear masks and configuration words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            for (int i = 0; i < NL; i++) cfg_q[i] <= '0;
        end else if (wr_acc) begin
            unique case (dec_sel)
                REG_SET: out_q[int'(dec_bank)*LINES +: LINES] <=
                         out_q[int'(dec_bank)*LINES +: LINES] | bus_wdata[LINES-1:0];
                REG_CLR: out_q[int'(dec_bank)*LINES +: LINES] <=
                         out_q[int'(dec_bank)*LINES +: LINES] & ~bus_wdata[LINES-1:0];
                REG_CFG: cfg_q[line_sel] <= '{fsel: bus_wdata[FSEL_LO +: FSEL_W],
                                              od:   bus_wdata[BIT_OD],
                                              inv:  bus_wdata[BIT_INV],
                                              oe:   bus_wdata[BIT_OE]};
                default: ;
            endcase
        end
    end

    // Read data selection
    always_comb begin
        rd_mux = '0;
        unique case (dec_sel)
            REG_RX:    rd_mux[LINES-1:0] = rx_v[int'(dec_bank)*LINES +: LINES];
            REG_SET:   rd_mux[LINES-1:0] = out_q[int'(dec_bank)*LINES +: LINES];
            REG_CONST: rd_mux[15:0]      = {BASE_VEC, 8'(NL)};
            REG_CFG: begin
                rd_mux[BIT_OE]              = cfg_rd.oe;
                rd_mux[BIT_INV]             = cfg_rd.inv;
                rd_mux[BIT_OD]              = cfg_rd.od;
                rd_mux[FSEL_LO +: FSEL_W]   = cfg_rd.fsel;
            end
            default: ;
        endcase
    end

    // Response state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_acc) rdata_q <= rd_mux;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_acc) state_d = ST_RDATA;
            ST_RDATA: state_d = rd_acc ? ST_RDATA : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_rvalid = (state_q == ST_RDATA);
        bus_rdata  = rdata_q;
    end

    // Assertions
    logic [NL-1:0] fn_mask;
    always_comb for (int i = 0; i < NL; i++) fn_mask[i] = (cfg_q[i].fsel != '0) | ~cfg_q[i].oe;

    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && dec_sel == REG_SET && !dec_bank) |=>
        ((out_q[LINES-1:0] & $past(bus_wdata[LINES-1:0])) == $past(bus_wdata[LINES-1:0])));
    a_r2_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && dec_sel == REG_SET && !dec_bank) |=>
        ((out_q[LINES-1:0] & ~$past(bus_wdata[LINES-1:0])) ==
         ($past(out_q[LINES-1:0]) & ~$past(bus_wdata[LINES-1:0]))));
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && dec_sel == REG_CLR && dec_bank) |=>
        ((out_q[NL-1:LINES] & $past(bus_wdata[LINES-1:0])) == '0));
    a_r9_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & fn_mask) == '0) && ((pad_out & fn_mask) == '0));
    a_r12_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid);
    a_r12_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !bus_rvalid);
    a_r13_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && dec_sel == REG_NONE) |=> $stable(out_q));
endmodule

// File: tb/sim_gpio_setclr_bank.sv
`timescale 1ns/1ps
module sim_gpio_setclr_bank;
    localparam int L  = 64;
    localparam int NL = 2 * L;

    logic           clk = 0;
    logic           rst_n = 0;
    logic           bus_req = 0, bus_we = 0;
    logic [12:0]    bus_addr = '0;
    logic [63:0]    bus_wdata = '0;
    logic [63:0]    bus_rdata;
    logic           bus_rvalid;
    logic [NL-1:0]  pad_in = '0;
    logic [NL-1:0]  pad_out, pad_oe;

    int errors = 0, checks = 0;
    bit done = 0;

    bit [NL-1:0] m_out;
    bit          m_oe [NL];
    bit          m_inv [NL];
    bit          m_od [NL];
    bit [9:0]    m_fs [NL];

    always #2.5 clk = ~clk;

    gpio_setclr_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [NL-1:0] exp_oe();
        bit [NL-1:0] r;
        for (int i = 0; i < NL; i++) begin
            bit v;
            v = m_out[i] ^ m_inv[i];
            r[i] = m_oe[i] && m_fs[i] == 0 && (m_od[i] ? !v : 1'b1);
        end
        return r;
    endfunction

    function automatic bit [NL-1:0] exp_out();
        bit [NL-1:0] r;
        for (int i = 0; i < NL; i++)
            r[i] = m_oe[i] && m_fs[i] == 0 && !m_od[i] && (m_out[i] ^ m_inv[i]);
        return r;
    endfunction

    function automatic bit [63:0] exp_rx(input int b);
        bit [63:0] r;
        for (int i = 0; i < L; i++) r[i] = pad_in[b*L+i] ^ m_inv[b*L+i];
        return r;
    endfunction

    function automatic bit [63:0] exp_cfg(input int ln);
        bit [63:0] r = '0;
        r[0] = m_oe[ln]; r[1] = m_inv[ln]; r[12] = m_od[ln]; r[25:16] = m_fs[ln];
        return r;
    endfunction

    function automatic logic [12:0] cfg_addr(input int b, input int i);
        return 13'(b * 'h1400 + 'h400 + 8 * i);
    endfunction

    task automatic wr(input logic [12:0] a, input logic [63:0] d);
        int b;
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
        b = (a >= 13'h1400) ? 1 : 0;
        if (a - 13'(b*'h1400) == 13'h8)       m_out[b*L +: L] = m_out[b*L +: L] | d;
        else if (a - 13'(b*'h1400) == 13'h10) m_out[b*L +: L] = m_out[b*L +: L] & ~d;
        else if (a - 13'(b*'h1400) >= 13'h400 && a - 13'(b*'h1400) < 13'h600
                 && a[2:0] == 0) begin
            int ln;
            ln = b*L + int'((a - 13'(b*'h1400) - 13'h400) >> 3);
            m_oe[ln] = d[0]; m_inv[ln] = d[1]; m_od[ln] = d[12]; m_fs[ln] = d[25:16];
        end
    endtask

    task automatic rd(input logic [12:0] a, output logic [63:0] d, output logic v);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic rd_chk(input string tag, input logic [12:0] a, input logic [63:0] exp);
        logic [63:0] d; logic v;
        rd(a, d, v);
        chk({tag, " rvalid"}, 128'(v), 128'(1));
        chk(tag, 128'(d), 128'(exp));
    endtask

    task automatic pad_chk(input string tag);
        chk({tag, " pad_oe"}, pad_oe, exp_oe());
        chk({tag, " pad_out"}, pad_out, exp_out());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] d; logic v;
        void'($urandom(32'd1234));
        m_out = '0;
        for (int i = 0; i < NL; i++) begin m_oe[i]=0; m_inv[i]=0; m_od[i]=0; m_fs[i]=0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rvalid", 128'(bus_rvalid), 128'(0));
        pad_chk("R1");
        rd_chk("R1 latch bank0", 13'h8, 64'h0);
        rd_chk("R1 cfg line3", cfg_addr(0, 3), 64'h0);
        // R11 constants in both banks
        rd_chk("R11 const0", 13'h90, 64'h3080);
        rd_chk("R11 const1", 13'h1490, 64'h3080);
        // R2 / R4 set and readback
        wr(13'h8, 64'h00F0_0000_0000_0F0F);
        rd_chk("R2 R4 set read", 13'h8, 64'h00F0_0000_0000_0F0F);
        rd_chk("R4 clr reads zero", 13'h10, 64'h0);
        // R3 clear
        wr(13'h10, 64'h0000_0000_0000_0303);
        rd_chk("R3 clear", 13'h8, 64'h00F0_0000_0000_0C0C);
        // R10 second bank independent
        wr(13'h1408, 64'h8000_0000_0000_0001);
        rd_chk("R10 bank1 latch", 13'h1408, 64'h8000_0000_0000_0001);
        rd_chk("R10 bank0 untouched", 13'h8, 64'h00F0_0000_0000_0C0C);
        // R12 write gives no response
        wr(13'h8, 64'h0);
        chk("R12 no rvalid after write", 128'(bus_rvalid), 128'(0));
        // R6 config fields, junk bits dropped
        wr(cfg_addr(0, 2), 64'hFFFF_FC00_0000_EFFC);
        rd_chk("R6 cfg fields", cfg_addr(0, 2), 64'h0000_0000_0000_0000);
        wr(cfg_addr(0, 2), 64'h1234_0000_0000_1003);
        rd_chk("R6 cfg readback", cfg_addr(0, 2), exp_cfg(2));
        // R7 push-pull on line 3 (latch 1) and line 4 (latch 0, inverted)
        wr(cfg_addr(0, 3), 64'h1);
        wr(cfg_addr(0, 4), 64'h3);
        pad_chk("R7 push-pull");
        chk("R7 line3 out", 128'(pad_out[3]), 128'(1));
        chk("R7 line4 out", 128'(pad_out[4]), 128'(1));
        // R8 open drain: line 2 latch 1 inv 1 -> level 0 -> pulls low
        chk("R8 od low drive", 128'({pad_oe[2], pad_out[2]}), 128'(2'b10));
        wr(cfg_addr(0, 5), 64'h1001);
        wr(13'h10, 64'h20);
        chk("R8 od latch0", 128'(pad_oe[5]), 128'(1));
        wr(13'h8, 64'h20);
        chk("R8 od release", 128'(pad_oe[5]), 128'(0));
        // R9 function select blocks drive
        wr(cfg_addr(1, 0), 64'h0001_0001);
        chk("R9 fsel blocks", 128'({pad_oe[64], pad_out[64]}), 128'(0));
        pad_chk("R9");
        // R5 input read with inversion
        pad_in = {$urandom, $urandom, $urandom, $urandom};
        rd_chk("R5 rx bank0", 13'h0, exp_rx(0));
        rd_chk("R5 rx bank1", 13'h1400, exp_rx(1));
        // R13 unmapped and unaligned
        rd_chk("R13 unmapped read", 13'h18, 64'h0);
        rd_chk("R13 unaligned read", 13'h404, 64'h0);
        wr(13'h18, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(13'h40C, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R13 write ignored latch", 13'h8, m_out[63:0]);
        rd_chk("R13 write ignored cfg", cfg_addr(0, 1), exp_cfg(1));
        pad_chk("R13 pads");
        // Random phase
        for (int n = 0; n < 400; n++) begin
            int b, k, idx;
            logic [63:0] w;
            b = $urandom_range(0, 1);
            k = $urandom_range(0, 4);
            idx = $urandom_range(0, L-1);
            w = {$urandom, $urandom};
            unique case (k)
                0: wr(13'(b*'h1400 + 'h8), w);
                1: wr(13'(b*'h1400 + 'h10), w);
                2: begin
                    if ($urandom_range(0, 3) != 0) w[25:16] = '0;
                    wr(cfg_addr(b, idx), w);
                end
                3: begin
                    pad_in = {$urandom, $urandom, $urandom, $urandom};
                    rd_chk("R5 random rx", 13'(b*'h1400), exp_rx(b));
                end
                default: rd_chk("R6 random cfg", cfg_addr(b, idx), exp_cfg(b*L + idx));
            endcase
            if (n % 8 == 0) begin
                pad_chk("R7 R8 R9 random");
                rd_chk("R2 R3 random latch", 13'(b*'h1400 + 'h8), m_out[b*L +: L]);
            end
        end
        // Read back-to-back keeps rvalid for each (R12)
        @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = 13'h90;
        @(negedge clk); chk("R12 rvalid 1", 128'(bus_rvalid), 128'(1));
        bus_addr = 13'h8;
        @(negedge clk); bus_req = 0;
        chk("R12 rvalid 2", 128'(bus_rvalid), 128'(1));
        chk("R12 rdata 2", 128'(bus_rdata), 128'(m_out[63:0]));
        @(negedge clk); chk("R12 rvalid drops", 128'(bus_rvalid), 128'(0));
        d = '0; v = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule